// File: doc/BRIEF.md
# Host Status and Interrupt Controller

This block keeps the three control-side registers of a card host: a status word, a configuration word and a debug word. The command and data paths report events as one-cycle set pulses, and software clears status bits by writing ones to them. When a data transfer finishes, the block raises interrupt-cause bits. Each cause is allowed only by its own configuration enable and, for two of them, only for the matching kind of command. One level interrupt line is asserted whenever any cause bit is set.

The debug word holds a 4-bit state field that moves to the data-mode code when a transfer completes. A software write that tries to store the power-down code 0xF in that field stores 0 instead. Bits 8:4 of the debug word are not storage: on every read they show the current FIFO fill level, cut to five bits. All register state, the interrupt line and the read data are flops on one clock with a synchronous active-high reset.

Top module: `hsirq_ctrl`

## Requirements
- R1: `irq_o` is high exactly when status bit 10 (busy), bit 9 (block) or bit 8 (data) is set. It is a flop that changes on the same edge as the status register.
- R2: A write with select 0 (status) clears every status bit whose write-data bit is 1 and leaves the other bits unchanged.
- R3: `evt_set` ORs into the status register. A bit that is set by an event and cleared by software in the same cycle ends up set.
- R4: A `xfer_done` pulse sets status bit 0 (data flag) and sets debug bits 3:0 to 1 (data mode).
- R5: On `xfer_done`, status bit 8 is set when config bit 4 is set. Bit 10 is set when `xfer_busywait` and config bit 10 are both high. Bit 9 is set when `xfer_write` and config bit 8 are both high. The gating uses the config value held before that clock edge.
- R6: A write with select 2 (debug) stores the write data. If its bits 3:0 are 0xF, the field is stored as 0.
- R7: When debug is read, bits 8:4 show `fifo_level` bits 4:0 as sampled at the read edge. Writes to those bits have no effect.
- R8: After reset, status reads 0, config reads 0, debug reads 0x0000C60F (with the FIFO level at 0) and `irq_o` is 0.
- R9: A write with select 1 (config) stores write-data bits 10:0. The upper bits of config and status read as 0.
- R10: If a debug write and `xfer_done` fall in the same cycle, debug bits 3:0 become 1.
- R11: `reg_rdata` is registered. After an edge it holds the register picked by `reg_rsel` as it was before that edge. Select 3 reads 0, and a write to select 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wsel | input | 2 | Write select: 0 status, 1 config, 2 debug, 3 none |
| reg_wdata | input | 32 | Write data |
| reg_rsel | input | 2 | Read select, same coding as the write select |
| reg_rdata | output | 32 | Registered read data |
| evt_set | input | 11 | Per-bit status set pulses from the command and data paths |
| xfer_done | input | 1 | Transfer completion pulse |
| xfer_busywait | input | 1 | The completing command waits for card busy |
| xfer_write | input | 1 | The completing command is a write |
| fifo_level | input | 6 | Current FIFO fill level |
| irq_o | output | 1 | Level interrupt |

## Verification
Directed completions are run under the config values 0x510, 0x000 and 0x010, with the busy-wait and write flags both high, and each outcome is compared with a literal value. This separates the three enables from each other and from the command-kind qualifiers. It also shows whether the gating reads the old config or one written in the same cycle. Other directed cycles place an event and a clear on the same bit, a debug write and a completion on the same edge, and debug writes with and without the 0xF nibble, together with out-of-range FIFO levels. A seeded random phase then mixes writes to all four selects, sparse event vectors, completions and changing FIFO levels. That phase checks every read and the interrupt line against a bench model built from the requirements.

// File: rtl/hsirq_pkg.sv
package hsirq_pkg;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_CONFIG = 2'd1,
    SEL_DEBUG  = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  // status bit positions decoded by the interrupt line and the completion gate
  localparam int ST_DATA_FLAG = 0;
  localparam int ST_DATA_IRQ  = 8;
  localparam int ST_BLOCK_IRQ = 9;
  localparam int ST_BUSY_IRQ  = 10;

  // config enable positions
  localparam int CF_DATA_EN  = 4;
  localparam int CF_BLOCK_EN = 8;
  localparam int CF_BUSY_EN  = 10;

  // debug word layout
  localparam int DBG_STATE_W = 4;
  localparam int DBG_LVL_LSB = 4;
  localparam int DBG_LVL_W   = 5;

  localparam logic [DBG_STATE_W-1:0] STATE_IDENT = 4'h0;
  localparam logic [DBG_STATE_W-1:0] STATE_DATA  = 4'h1;
  localparam logic [DBG_STATE_W-1:0] STATE_PDOWN = 4'hF;

endpackage

// File: rtl/hsirq_done_gate.sv
module hsirq_done_gate
  import hsirq_pkg::*;
#(
  parameter int STAT_W = 11,
  parameter int CFG_W  = 11
) (
  input  logic              done,
  input  logic              busywait,
  input  logic              wr_cmd,
  input  logic [CFG_W-1:0]  cfg,
  output logic [STAT_W-1:0] set_vec
);

  logic unused_cfg;
  assign unused_cfg = ^cfg;

  always_comb begin
    set_vec = '0;
    if (done) begin
      set_vec[ST_DATA_FLAG] = 1'b1;
      set_vec[ST_DATA_IRQ]  = cfg[CF_DATA_EN];
      set_vec[ST_BUSY_IRQ]  = busywait & cfg[CF_BUSY_EN];
      set_vec[ST_BLOCK_IRQ] = wr_cmd & cfg[CF_BLOCK_EN];
    end
  end

endmodule

// File: rtl/hsirq_status_reg.sv
module hsirq_status_reg
  import hsirq_pkg::*;
#(
  parameter int STAT_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_en,
  input  logic [STAT_W-1:0] clr_mask,
  input  logic [STAT_W-1:0] set_mask,
  output logic [STAT_W-1:0] stat_q,
  output logic              irq_q
);

  localparam int IRQ_LO = ST_DATA_IRQ;
  localparam int IRQ_HI = ST_BUSY_IRQ;

  logic [STAT_W-1:0] stat_n;

  // set has priority over the write-one-to-clear on every bit
  for (genvar i = 0; i < STAT_W; i++) begin : g_bit
    assign stat_n[i] = set_mask[i] | (stat_q[i] & ~(clr_en & clr_mask[i]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_n;
      irq_q  <= |stat_n[IRQ_HI:IRQ_LO];
    end
  end

endmodule

// File: rtl/hsirq_cfg_dbg.sv
module hsirq_cfg_dbg
  import hsirq_pkg::*;
#(
  parameter int               DATA_W    = 32,
  parameter int               CFG_W     = 11,
  parameter logic [DATA_W-1:0] DBG_RESET = 32'h0000_C60F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              dbg_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              done,
  output logic [CFG_W-1:0]  cfg_q,
  output logic [DATA_W-1:0] dbg_q
);

  localparam logic [DATA_W-1:0] LVL_MASK =
    DATA_W'(((1 << DBG_LVL_W) - 1) << DBG_LVL_LSB);
  localparam logic [DATA_W-1:0] DBG_INIT = DBG_RESET & ~LVL_MASK;

  logic [DATA_W-1:0] dbg_wval;
  logic [DATA_W-1:0] dbg_n;

  always_comb begin
    dbg_wval = wdata & ~LVL_MASK;
    if (wdata[DBG_STATE_W-1:0] == STATE_PDOWN)
      dbg_wval[DBG_STATE_W-1:0] = STATE_IDENT;
  end

  always_comb begin
    dbg_n = dbg_q;
    if (dbg_we)
      dbg_n = dbg_wval;
    if (done)
      dbg_n[DBG_STATE_W-1:0] = STATE_DATA;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
      dbg_q <= DBG_INIT;
    end else begin
      if (cfg_we)
        cfg_q <= wdata[CFG_W-1:0];
      dbg_q <= dbg_n;
    end
  end

endmodule

// File: rtl/hsirq_ctrl.sv
module hsirq_ctrl
  import hsirq_pkg::*;
#(
  parameter int                DATA_W    = 32,
  parameter int                STAT_W    = 11,
  parameter int                CFG_W     = 11,
  parameter int                LVL_W     = 6,
  parameter logic [DATA_W-1:0] DBG_RESET = 32'h0000_C60F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [1:0]        reg_wsel,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [1:0]        reg_rsel,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [STAT_W-1:0] evt_set,
  input  logic              xfer_done,
  input  logic              xfer_busywait,
  input  logic              xfer_write,
  input  logic [LVL_W-1:0]  fifo_level,
  output logic              irq_o
);

  logic [STAT_W-1:0] done_set;
  logic [STAT_W-1:0] stat_q;
  logic [CFG_W-1:0]  cfg_q;
  logic [DATA_W-1:0] dbg_q;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] dbg_view;
  logic              wr_status;
  logic              wr_config;
  logic              wr_debug;

  assign wr_status = reg_wr && (reg_wsel == SEL_STATUS);
  assign wr_config = reg_wr && (reg_wsel == SEL_CONFIG);
  assign wr_debug  = reg_wr && (reg_wsel == SEL_DEBUG);

  hsirq_done_gate #(.STAT_W(STAT_W), .CFG_W(CFG_W)) u_gate (
    .done    (xfer_done),
    .busywait(xfer_busywait),
    .wr_cmd  (xfer_write),
    .cfg     (cfg_q),
    .set_vec (done_set)
  );

  hsirq_status_reg #(.STAT_W(STAT_W)) u_status (
    .clk     (clk),
    .rst     (rst),
    .clr_en  (wr_status),
    .clr_mask(reg_wdata[STAT_W-1:0]),
    .set_mask(evt_set | done_set),
    .stat_q  (stat_q),
    .irq_q   (irq_o)
  );

  hsirq_cfg_dbg #(.DATA_W(DATA_W), .CFG_W(CFG_W), .DBG_RESET(DBG_RESET)) u_cfgdbg (
    .clk   (clk),
    .rst   (rst),
    .cfg_we(wr_config),
    .dbg_we(wr_debug),
    .wdata (reg_wdata),
    .done  (xfer_done),
    .cfg_q (cfg_q),
    .dbg_q (dbg_q)
  );

  // bits 8:4 of debug show the live FIFO level instead of stored bits
  always_comb begin
    dbg_view = dbg_q;
    dbg_view[DBG_LVL_LSB +: DBG_LVL_W] = fifo_level[DBG_LVL_W-1:0];
  end

  always_comb begin
    case (reg_rsel)
      SEL_STATUS: rd_mux = DATA_W'(stat_q);
      SEL_CONFIG: rd_mux = DATA_W'(cfg_q);
      SEL_DEBUG:  rd_mux = dbg_view;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end

  logic unused_top;
  assign unused_top = ^{reg_wdata[DATA_W-1:STAT_W], fifo_level,
                        dbg_q[DBG_LVL_LSB +: DBG_LVL_W]};

endmodule

// File: rtl/hsirq_chk.sv
module hsirq_chk #(
  parameter int DATA_W = 32,
  parameter int STAT_W = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [1:0]        reg_wsel,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [STAT_W-1:0] evt_set,
  input logic              xfer_done,
  input logic [STAT_W-1:0] stat_q,
  input logic [3:0]        dbg_state,
  input logic              irq_o
);

  logic unused_chk;
  assign unused_chk = ^reg_wdata[DATA_W-1:STAT_W];

  AST_IRQ_TRACKS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    irq_o == (|stat_q[10:8])); // R1

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_wsel == 2'd0 && !xfer_done) |=>
      ((stat_q & $past(reg_wdata[STAT_W-1:0] & ~evt_set)) == '0)); // R2

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (evt_set != '0) |=> ((stat_q & $past(evt_set)) == $past(evt_set))); // R3

  AST_DONE_MARKS: assert property (@(posedge clk) disable iff (rst)
    xfer_done |=> (stat_q[0] && dbg_state == 4'h1)); // R4

  AST_NO_PDOWN_STORE: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_wsel == 2'd2 && reg_wdata[3:0] == 4'hF && !xfer_done) |=>
      (dbg_state == 4'h0)); // R6

endmodule

bind hsirq_ctrl hsirq_chk #(.DATA_W(DATA_W), .STAT_W(STAT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .reg_wr   (reg_wr),
  .reg_wsel (reg_wsel),
  .reg_wdata(reg_wdata),
  .evt_set  (evt_set),
  .xfer_done(xfer_done),
  .stat_q   (stat_q),
  .dbg_state(dbg_q[3:0]),
  .irq_o    (irq_o)
);

// File: tb/hsirq_ctrl_tb.sv
module hsirq_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        reg_wr;
  logic [1:0]  reg_wsel;
  logic [31:0] reg_wdata;
  logic [1:0]  reg_rsel;
  logic [31:0] reg_rdata;
  logic [10:0] evt_set;
  logic        xfer_done;
  logic        xfer_busywait;
  logic        xfer_write;
  logic [5:0]  fifo_level;
  logic        irq_o;

  int n_chk = 0;
  int n_err = 0;

  logic [10:0] m_stat;
  logic [10:0] m_cfg;
  logic [31:0] m_dbg;

  always #2.5 clk = ~clk;

  hsirq_ctrl u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wsel(reg_wsel),
    .reg_wdata(reg_wdata), .reg_rsel(reg_rsel), .reg_rdata(reg_rdata),
    .evt_set(evt_set), .xfer_done(xfer_done), .xfer_busywait(xfer_busywait),
    .xfer_write(xfer_write), .fifo_level(fifo_level), .irq_o(irq_o)
  );

  function automatic logic [31:0] f_read(input logic [1:0] sel, input logic [10:0] st,
                                         input logic [10:0] cf, input logic [31:0] dbg,
                                         input logic [5:0] lvl);
    logic [31:0] d;
    d = dbg;
    d[8:4] = lvl[4:0];
    case (sel)
      2'd0:    return {21'd0, st};
      2'd1:    return {21'd0, cf};
      2'd2:    return d;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [10:0] f_done_bits(input logic dn, input logic bw,
                                              input logic wc, input logic [10:0] cf);
    logic [10:0] b;
    b = '0;
    if (dn) begin
      b[0]  = 1'b1;
      b[8]  = cf[4];
      b[10] = bw & cf[10];
      b[9]  = wc & cf[8];
    end
    return b;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_update();
    logic [10:0] clr;
    logic [31:0] w;
    if (rst) begin
      m_stat = '0; m_cfg = '0; m_dbg = 32'h0000_C60F;
    end else begin
      clr = (reg_wr && reg_wsel == 2'd0) ? reg_wdata[10:0] : 11'd0;
      m_stat = (m_stat & ~clr) | evt_set |
               f_done_bits(xfer_done, xfer_busywait, xfer_write, m_cfg);
      if (reg_wr && reg_wsel == 2'd1) m_cfg = reg_wdata[10:0];
      if (reg_wr && reg_wsel == 2'd2) begin
        w = reg_wdata;
        w[8:4] = 5'd0;
        if (w[3:0] == 4'hF) w[3:0] = 4'h0;
        m_dbg = w;
      end
      if (xfer_done) m_dbg[3:0] = 4'h1;
    end
  endtask

  // one clock: expected read value from state before the edge
  task automatic tick();
    logic [31:0] exp_rd;
    exp_rd = rst ? 32'd0 : f_read(reg_rsel, m_stat, m_cfg, m_dbg, fifo_level);
    @(posedge clk);
    #1;
    model_update();
    check("R11 rdata", reg_rdata, exp_rd);
    check("R1 irq", {31'd0, irq_o}, {31'd0, |m_stat[10:8]});
  endtask

  task automatic idle();
    reg_wr = 0; reg_wsel = 0; reg_wdata = 0; evt_set = 0;
    xfer_done = 0; xfer_busywait = 0; xfer_write = 0;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    idle();
    reg_wr = 1; reg_wsel = sel; reg_wdata = d;
    tick();
    idle();
  endtask

  task automatic rd(input logic [1:0] sel, input logic [31:0] exp, input string tag);
    idle();
    reg_rsel = sel;
    tick();
    check(tag, reg_rdata, exp);
  endtask

  task automatic done(input logic bw, input logic wc);
    idle();
    xfer_done = 1; xfer_busywait = bw; xfer_write = wc;
    tick();
    idle();
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5D1C_0A7E);
    idle();
    reg_rsel = 0; fifo_level = 0;
    m_stat = '0; m_cfg = '0; m_dbg = 32'h0000_C60F;
    rst = 1;
    repeat (3) tick();
    rst = 0;

    // R8 reset values
    rd(2'd0, 32'h0, "R8 status reset");
    rd(2'd1, 32'h0, "R8 config reset");
    rd(2'd2, 32'h0000_C60F, "R8 debug reset");
    check("R8 irq reset", {31'd0, irq_o}, 32'd0);

    // R7 level field
    fifo_level = 6'h13;
    rd(2'd2, 32'h0000_C73F, "R7 level shown");
    fifo_level = 6'h3F;
    rd(2'd2, 32'h0000_C7FF, "R7 level masked");
    fifo_level = 0;

    // R9 config storage
    wr(2'd1, 32'h0000_0510);
    rd(2'd1, 32'h0000_0510, "R9 config store");
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, 32'h0000_07FF, "R9 config upper zero");
    wr(2'd1, 32'h0000_0510);

    // R4/R5 all enables
    done(1, 1);
    rd(2'd0, 32'h0000_0701, "R5 all causes");
    check("R1 irq on causes", {31'd0, irq_o}, 32'd1);
    rd(2'd2, 32'h0000_C601, "R4 state data mode");

    // R2 write-one-to-clear
    wr(2'd0, 32'h0000_0100);
    rd(2'd0, 32'h0000_0601, "R2 clear bit8");
    wr(2'd0, 32'h0000_0600);
    rd(2'd0, 32'h0000_0001, "R2 clear bits10:9");
    check("R1 irq low", {31'd0, irq_o}, 32'd0);

    // R5 no enables
    wr(2'd0, 32'h0000_07FF);
    wr(2'd1, 32'h0);
    done(1, 1);
    rd(2'd0, 32'h0000_0001, "R5 no enables");

    // R5 data enable only
    wr(2'd1, 32'h0000_0010);
    done(1, 1);
    rd(2'd0, 32'h0000_0101, "R5 data enable only");

    // R3 set wins over clear
    idle();
    reg_wr = 1; reg_wsel = 2'd0; reg_wdata = 32'h0000_0101; evt_set = 11'h100;
    tick();
    idle();
    rd(2'd0, 32'h0000_0100, "R3 set beats clear");

    // R6 debug writes
    wr(2'd2, 32'h1234_567F);
    rd(2'd2, 32'h1234_5600, "R6 nibble F to 0");
    wr(2'd2, 32'hABCD_E9A5);
    rd(2'd2, 32'hABCD_E805, "R6 plain store");

    // R10 debug write and completion together
    idle();
    reg_wr = 1; reg_wsel = 2'd2; reg_wdata = 32'h0000_000F; xfer_done = 1;
    tick();
    idle();
    rd(2'd2, 32'h0000_0001, "R10 done wins state");

    // R11 select 3
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, 32'h0, "R11 select3 zero");
    rd(2'd1, 32'h0000_0010, "R11 config untouched");
    rd(2'd2, 32'h0000_0001, "R11 debug untouched");

    // R5 gating uses old config
    wr(2'd0, 32'h0000_07FF);
    idle();
    reg_wr = 1; reg_wsel = 2'd1; reg_wdata = 32'h0000_0510;
    xfer_done = 1; xfer_busywait = 1; xfer_write = 1;
    tick();
    idle();
    rd(2'd0, 32'h0000_0101, "R5 old config gates");

    // random phase
    for (int i = 0; i < 800; i++) begin
      reg_wr        = ($urandom % 3) == 0;
      reg_wsel      = 2'($urandom % 4);
      reg_wdata     = $urandom;
      reg_rsel      = 2'($urandom % 4);
      evt_set       = (($urandom % 6) == 0) ? 11'($urandom) : 11'd0;
      xfer_done     = ($urandom % 5) == 0;
      xfer_busywait = 1'($urandom);
      xfer_write    = 1'($urandom);
      fifo_level    = 6'($urandom);
      tick();
    end
    idle();

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule